// File: doc/BRIEF.md
# Debug Abstract Register-Command Controller

This block sits between a debugger-facing register port and a group of processor harts. Software writes a command word that names a hart register, a transfer direction and an access size. The controller checks the command and, when it is acceptable, runs one request/acknowledge exchange with the hart picked by `hart_sel`. A register read places the returned value in data word 0. A register write sends data word 0 to the hart. A status word shows a busy flag and a sticky three-bit error code, and software clears that code by writing ones to it.

The accepted command is kept in a private copy. Each data word and each program-buffer word has a bit in an auto-run mask. When software reads or writes a word whose mask bit is set, the controller runs the kept command again with its original register number. Scripted debuggers use this to stream values through data word 0 without rewriting the command each time. The real processor, memory-access commands and the serial debug transport are outside this block.

Register word addresses (`reg_addr`): data words at 0x00 upward, program-buffer words at 0x08 upward, status at 0x10 (busy in bit 12, error code in bits 10:8), command at 0x11, and the auto-run mask at 0x12 (data-word bits from bit 0, program-buffer bits from bit 16). Command word: kind in bits 31:24, which must be 0, size in bits 22:20, transfer flag in bit 17, write flag in bit 16, register number in bits 15:0. Bits 23 and 19:18 are reserved and must be zero.

Top module: `abs_cmd_ctrl`

## Requirements
- R1: After reset the status reads 0 (error code 0, not busy), `xfer_valid` is low and every data word reads 0.
- R2: A valid command has kind 0, size 2 and a register number in 0x1000..0x101F, with the transfer flag set. It raises `xfer_valid` in the cycle after the write and presents the register number, the write flag and the selected hart. A read stores `xfer_rdata` into data word 0. A write drives data word 0 on `xfer_wdata`. The status busy bit is 1 while the request is open.
- R3: When the transfer flag is 0, the size and register-number fields are ignored. No request is made and the error code stays 0.
- R4: A non-zero kind, non-zero reserved bits, or (with transfer set) a size other than 2 or a register number outside 0x1000..0x101F sets error code 2 and makes no request.
- R5: A transfer command to a hart whose `hart_halted` bit is 0 sets error code 4 and makes no request.
- R6: A command write or an auto-run access while a request is open sets error code 1 if the code was 0. The new command is not run, and the open request keeps its register number.
- R7: While the error code is non-zero, command writes and auto-run accesses start nothing.
- R8: Writing the status word clears each error-code bit that is 1 in bits 10:8 of the write data. Zeros leave the code unchanged.
- R9: A read or write of a data word or program-buffer word whose auto-run bit is set runs the kept command again. The request uses the kept register number, not any value from the access.
- R10: An open request follows only the hart captured at its start. Ready from any other hart, or a change of `hart_sel`, does not finish it. If the captured hart drops `hart_halted`, the request is dropped and error code 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (only affects auto-run) |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| hart_sel | input | HW | Selected hart index |
| hart_halted | input | NHART | Per-hart halted status |
| hart_ready | input | NHART | Per-hart acknowledge of an open request |
| xfer_rdata | input | 32 | Register value returned by the hart |
| xfer_valid | output | 1 | Request open toward the hart |
| xfer_hart | output | HW | Hart that the request targets |
| xfer_regno | output | 16 | Register number of the request |
| xfer_write | output | 1 | 1 = write hart register, 0 = read |
| xfer_wdata | output | 32 | Data for a register write (data word 0) |

## Verification
Two cases are hard to reach from the ports. One is an auto-run replay where the bus value differs from the kept register number. The other is a request whose target hart stops being the selected one while it is open. The bench first runs a read of one register to completion. It then writes a data word whose value looks like a different register number, and checks which number reaches the hart. For the second case the bench holds the target hart's ready low, moves `hart_sel` and raises ready on another hart. It then drops the halted flag of the original hart, which should force the abort path.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int XLEN = 32;

    // register word addresses
    localparam logic [4:0] A_STATUS = 5'h10;
    localparam logic [4:0] A_CMD    = 5'h11;
    localparam logic [4:0] A_AUTO   = 5'h12;

    localparam int STAT_ERR_LSB = 8;
    localparam int STAT_BUSY    = 12;
    localparam int AUTO_PROG_LSB = 16;

    // error codes
    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_BUSY  = 3'd1;
    localparam logic [2:0] ERR_NOSUP = 3'd2;
    localparam logic [2:0] ERR_HALT  = 3'd4;

    localparam logic [2:0]  SIZE_WORD = 3'd2;
    localparam logic [10:0] REG_GRP   = 11'h080; // 0x1000 >> 5

    typedef struct packed {
        logic [7:0]  kind;
        logic        rsv_hi;
        logic [2:0]  size;
        logic [1:0]  rsv_lo;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
    } acc_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1
    } acc_state_e;

    function automatic logic [2:0] cmd_check(input acc_cmd_t c, input logic halted);
        logic [2:0] e;
        e = ERR_NONE;
        if (c.kind != 8'd0 || c.rsv_hi || c.rsv_lo != 2'b00)
            e = ERR_NOSUP;
        else if (c.transfer) begin
            if (c.size != SIZE_WORD || c.regno[15:5] != REG_GRP)
                e = ERR_NOSUP;
            else if (!halted)
                e = ERR_HALT;
        end
        return e;
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  acc_cmd_t   cmd_i,
    input  logic       halted_i,
    output logic [2:0] err_o,
    output logic       go_o
);
    always_comb begin
        err_o = cmd_check(cmd_i, halted_i);
        go_o  = (err_o == ERR_NONE) && cmd_i.transfer;
    end
endmodule

// File: rtl/acc_regs.sv
module acc_regs
    import acc_pkg::*;
#(
    parameter int NDATA = 2,
    parameter int NPROG = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic            reg_re,
    input  logic [4:0]      reg_addr,
    input  logic [XLEN-1:0] reg_wdata,
    input  logic            load_en,
    input  logic [XLEN-1:0] load_val,
    input  logic            busy,
    input  logic [2:0]      cmderr,
    output logic [XLEN-1:0] data0,
    output logic [XLEN-1:0] rdata,
    output logic            auto_hit
);
    logic [XLEN-1:0]  data_q [NDATA];
    logic [XLEN-1:0]  prog_q [NPROG];
    logic [NDATA-1:0] amask_d;
    logic [NPROG-1:0] amask_p;

    logic       in_data, in_prog;
    logic [2:0] idx;

    assign idx     = reg_addr[2:0];
    assign in_data = (reg_addr[4:3] == 2'b00) && (int'(idx) < NDATA);
    assign in_prog = (reg_addr[4:3] == 2'b01) && (int'(idx) < NPROG);

    genvar gi;
    generate
        for (gi = 0; gi < NDATA; gi++) begin : g_data
            always_ff @(posedge clk) begin
                if (rst)
                    data_q[gi] <= '0;
                else if (gi == 0 && load_en)
                    data_q[gi] <= load_val;
                else if (reg_we && in_data && int'(idx) == gi)
                    data_q[gi] <= reg_wdata;
            end
        end
        for (gi = 0; gi < NPROG; gi++) begin : g_prog
            always_ff @(posedge clk) begin
                if (rst)
                    prog_q[gi] <= '0;
                else if (reg_we && in_prog && int'(idx) == gi)
                    prog_q[gi] <= reg_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            amask_d <= '0;
            amask_p <= '0;
        end else if (reg_we && reg_addr == A_AUTO) begin
            amask_d <= reg_wdata[NDATA-1:0];
            amask_p <= reg_wdata[AUTO_PROG_LSB +: NPROG];
        end
    end

    assign data0 = data_q[0];

    always_comb begin
        auto_hit = 1'b0;
        for (int i = 0; i < NDATA; i++)
            if (in_data && int'(idx) == i && amask_d[i]) auto_hit = 1'b1;
        for (int i = 0; i < NPROG; i++)
            if (in_prog && int'(idx) == i && amask_p[i]) auto_hit = 1'b1;
        auto_hit = auto_hit && (reg_we || reg_re);
    end

    always_comb begin
        rdata = '0;
        if (in_data) begin
            for (int i = 0; i < NDATA; i++)
                if (int'(idx) == i) rdata = data_q[i];
        end else if (in_prog) begin
            for (int i = 0; i < NPROG; i++)
                if (int'(idx) == i) rdata = prog_q[i];
        end else if (reg_addr == A_STATUS) begin
            rdata[STAT_ERR_LSB +: 3] = cmderr;
            rdata[STAT_BUSY]         = busy;
        end else if (reg_addr == A_AUTO) begin
            rdata[NDATA-1:0]             = amask_d;
            rdata[AUTO_PROG_LSB +: NPROG] = amask_p;
        end
    end
endmodule

// File: rtl/acc_fsm.sv
module acc_fsm
    import acc_pkg::*;
#(
    parameter int NHART = 4,
    parameter int HW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      start_regno,
    input  logic             start_write,
    input  logic [HW-1:0]    hart_sel,
    input  logic [NHART-1:0] hart_ready,
    input  logic [NHART-1:0] hart_halted,
    output logic             xfer_valid,
    output logic [HW-1:0]    xfer_hart,
    output logic [15:0]      xfer_regno,
    output logic             xfer_write,
    output logic             busy,
    output logic             done_read,
    output logic             abort
);
    acc_state_e state_q, state_d;
    logic [HW-1:0] hart_q;
    logic [15:0]   regno_q;
    logic          write_q;
    logic          cur_halted, cur_ready;

    assign cur_halted = hart_halted[hart_q];
    assign cur_ready  = hart_ready[hart_q];

    always_comb begin
        state_d   = state_q;
        done_read = 1'b0;
        abort     = 1'b0;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_REQ;
            ST_REQ: begin
                if (!cur_halted) begin
                    abort   = 1'b1;
                    state_d = ST_IDLE;
                end else if (cur_ready) begin
                    done_read = !write_q;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hart_q  <= '0;
            regno_q <= '0;
            write_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                hart_q  <= hart_sel;
                regno_q <= start_regno;
                write_q <= start_write;
            end
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign xfer_valid = (state_q == ST_REQ);
    assign xfer_hart  = hart_q;
    assign xfer_regno = regno_q;
    assign xfer_write = write_q;
endmodule

// File: rtl/abs_cmd_ctrl.sv
module abs_cmd_ctrl
    import acc_pkg::*;
#(
    parameter int NHART = 4,
    parameter int NDATA = 2,
    parameter int NPROG = 2,
    localparam int HW   = (NHART > 1) ? $clog2(NHART) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [4:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [HW-1:0]    hart_sel,
    input  logic [NHART-1:0] hart_halted,
    input  logic [NHART-1:0] hart_ready,
    input  logic [31:0]      xfer_rdata,
    output logic             xfer_valid,
    output logic [HW-1:0]    xfer_hart,
    output logic [15:0]      xfer_regno,
    output logic             xfer_write,
    output logic [31:0]      xfer_wdata
);
    logic [2:0] cmderr_q;
    acc_cmd_t   last_cmd_q, exec_cmd;
    logic       cmd_wr, stat_wr, auto_hit, trig;
    logic       busy, done_read, abort, start;
    logic [2:0] dec_err;
    logic       dec_go;
    logic [31:0] data0;

    assign cmd_wr   = reg_we && reg_addr == A_CMD;
    assign stat_wr  = reg_we && reg_addr == A_STATUS;
    assign trig     = cmd_wr || auto_hit;
    assign exec_cmd = cmd_wr ? acc_cmd_t'(reg_wdata) : last_cmd_q;
    assign start    = trig && !busy && cmderr_q == ERR_NONE && dec_go;

    acc_decode u_dec (
        .cmd_i    (exec_cmd),
        .halted_i (hart_halted[hart_sel]),
        .err_o    (dec_err),
        .go_o     (dec_go)
    );

    acc_regs #(.NDATA(NDATA), .NPROG(NPROG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .load_en   (done_read),
        .load_val  (xfer_rdata),
        .busy      (busy),
        .cmderr    (cmderr_q),
        .data0     (data0),
        .rdata     (reg_rdata),
        .auto_hit  (auto_hit)
    );

    acc_fsm #(.NHART(NHART), .HW(HW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_regno (exec_cmd.regno),
        .start_write (exec_cmd.write),
        .hart_sel    (hart_sel),
        .hart_ready  (hart_ready),
        .hart_halted (hart_halted),
        .xfer_valid  (xfer_valid),
        .xfer_hart   (xfer_hart),
        .xfer_regno  (xfer_regno),
        .xfer_write  (xfer_write),
        .busy        (busy),
        .done_read   (done_read),
        .abort       (abort)
    );

    assign xfer_wdata = data0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmderr_q   <= ERR_NONE;
            last_cmd_q <= '0;
        end else begin
            if (stat_wr)
                cmderr_q <= cmderr_q & ~reg_wdata[STAT_ERR_LSB +: 3];
            if (abort && cmderr_q == ERR_NONE)
                cmderr_q <= ERR_HALT;
            else if (trig && cmderr_q == ERR_NONE) begin
                if (busy)
                    cmderr_q <= ERR_BUSY;
                else if (dec_err != ERR_NONE)
                    cmderr_q <= dec_err;
            end
            if (cmd_wr && !busy && cmderr_q == ERR_NONE)
                last_cmd_q <= acc_cmd_t'(reg_wdata);
        end
    end
endmodule

// File: rtl/acc_chk.sv
module acc_chk #(
    parameter int NHART = 4,
    parameter int HW    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [4:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [NHART-1:0] hart_halted,
    input logic [NHART-1:0] hart_ready,
    input logic             xfer_valid,
    input logic [HW-1:0]    xfer_hart,
    input logic [15:0]      xfer_regno,
    input logic [2:0]       cmderr
);
    logic cmd_w, stat_clr_all, tgt_halted, tgt_ready;
    assign cmd_w        = reg_we && reg_addr == 5'h11;
    assign stat_clr_all = reg_we && reg_addr == 5'h10 && reg_wdata[10:8] == 3'b111;
    assign tgt_halted   = hart_halted[xfer_hart];
    assign tgt_ready    = hart_ready[xfer_hart];

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!xfer_valid && cmderr == 3'd0));

    assert_finish_R2: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && tgt_halted && tgt_ready) |=> !xfer_valid);

    assert_busy_err_R6: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && tgt_halted && cmd_w && cmderr == 3'd0) |=> cmderr == 3'd1);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (cmderr != 3'd0 && !xfer_valid) |=> !xfer_valid);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_clr_all && !xfer_valid) |=> cmderr == 3'd0);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && tgt_halted && !tgt_ready)
        |=> (xfer_valid && $stable(xfer_regno) && $stable(xfer_hart)));

    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !tgt_halted) |=> (!xfer_valid && cmderr != 3'd0));
endmodule

bind abs_cmd_ctrl acc_chk #(.NHART(NHART), .HW(HW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .hart_halted (hart_halted),
    .hart_ready  (hart_ready),
    .xfer_valid  (xfer_valid),
    .xfer_hart   (xfer_hart),
    .xfer_regno  (xfer_regno),
    .cmderr      (cmderr_q)
);

// File: tb/abs_cmd_ctrl_tb.sv
module abs_cmd_ctrl_tb;
    localparam int NHART = 4;
    localparam int HW    = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_we = 1'b0, reg_re = 1'b0;
    logic [4:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [HW-1:0]   hart_sel = '0;
    logic [NHART-1:0] hart_halted = '1;
    logic [NHART-1:0] hart_ready = '1;
    logic [31:0]     xfer_rdata;
    logic            xfer_valid, xfer_write;
    logic [HW-1:0]   xfer_hart;
    logic [15:0]     xfer_regno;
    logic [31:0]     xfer_wdata;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    // hart model: value depends on target hart and register
    assign xfer_rdata = 32'hA500_0000 | ({30'd0, xfer_hart} << 16) | {16'd0, xfer_regno};

    abs_cmd_ctrl #(.NHART(NHART), .NDATA(2), .NPROG(2)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hart_sel(hart_sel), .hart_halted(hart_halted), .hart_ready(hart_ready),
        .xfer_rdata(xfer_rdata), .xfer_valid(xfer_valid), .xfer_hart(xfer_hart),
        .xfer_regno(xfer_regno), .xfer_write(xfer_write), .xfer_wdata(xfer_wdata)
    );

    // {cmd[31:0], halted[3:0], hsel[1:0], err[2:0]}
    localparam logic [40:0] VEC [8] = '{
        {32'h0022_1005, 4'hF, 2'd0, 3'd0},
        {32'h0023_1001, 4'hF, 2'd1, 3'd0},
        {32'h0070_FFFF, 4'hF, 2'd0, 3'd0},
        {32'h0032_1000, 4'hF, 2'd0, 3'd2},
        {32'h0022_2000, 4'hF, 2'd0, 3'd2},
        {32'h0122_1000, 4'hF, 2'd0, 3'd2},
        {32'h0022_1003, 4'hD, 2'd1, 3'd4},
        {32'h0022_101F, 4'h4, 2'd2, 3'd0}
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 5'h1F; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 5'h1F;
    endtask

    initial begin
        #4ms;
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, exp_d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h10, r);  check(r == 32'h0, "R1 status", r, 0);
        check(xfer_valid == 1'b0, "R1 xfer_valid", {31'd0, xfer_valid}, 0);
        rd(5'h00, r);  check(r == 32'h0, "R1 data0", r, 0);
        exp_d0 = 32'h0;

        // table of commands (R2 R3 R4 R5)
        for (int i = 0; i < 8; i++) begin
            logic [31:0] cmd;
            logic [2:0]  eerr;
            logic        exfer;
            cmd  = VEC[i][40:9];
            hart_halted = VEC[i][8:5];
            hart_sel    = VEC[i][4:3];
            eerr  = VEC[i][2:0];
            exfer = (eerr == 3'd0) && cmd[17];
            wr(5'h10, 32'h0000_0700);
            wr(5'h11, cmd);
            check(xfer_valid == exfer, "R2/R3/R4/R5 request", {31'd0, xfer_valid}, {31'd0, exfer});
            if (exfer) begin
                check(xfer_regno == cmd[15:0] && xfer_hart == hart_sel && xfer_write == cmd[16],
                      "R2 fields", {14'd0, xfer_hart, xfer_regno}, {14'd0, hart_sel, cmd[15:0]});
                if (cmd[16])
                    check(xfer_wdata == exp_d0, "R2 wdata", xfer_wdata, exp_d0);
                rd(5'h10, r);
                check(r[12] == 1'b0, "R2 busy done", r, 0);
                if (!cmd[16]) exp_d0 = 32'hA500_0000 | ({30'd0, hart_sel} << 16) | {16'd0, cmd[15:0]};
            end else begin
                rd(5'h10, r);
            end
            check(r[10:8] == eerr, "R3/R4/R5 cmderr", {29'd0, r[10:8]}, {29'd0, eerr});
            rd(5'h00, r);
            check(r == exp_d0, "R2 data0", r, exp_d0);
        end

        hart_halted = 4'hF; hart_sel = 2'd0; hart_ready = 4'hF;

        // R6 busy, then R7 sticky, then R8 w1c
        hart_ready = 4'h0;
        wr(5'h11, 32'h0022_1004);
        check(xfer_valid == 1'b1, "R6 first open", {31'd0, xfer_valid}, 1);
        rd(5'h10, r);
        check(r[12] == 1'b1, "R2 busy bit", r, 32'h1000);
        wr(5'h11, 32'h0022_1009);
        rd(5'h10, r);
        check(r[10:8] == 3'd1, "R6 busy code", {29'd0, r[10:8]}, 1);
        check(xfer_regno == 16'h1004, "R6 regno kept", {16'd0, xfer_regno}, 32'h1004);
        hart_ready = 4'hF;
        @(negedge clk);
        check(xfer_valid == 1'b0, "R6 finish", {31'd0, xfer_valid}, 0);
        rd(5'h00, r);
        check(r == 32'hA500_1004, "R6 no rerun", r, 32'hA500_1004);
        wr(5'h11, 32'h0022_1006);
        check(xfer_valid == 1'b0, "R7 ignored", {31'd0, xfer_valid}, 0);
        wr(5'h10, 32'h0);
        rd(5'h10, r);
        check(r[10:8] == 3'd1, "R8 zero write", {29'd0, r[10:8]}, 1);
        wr(5'h10, 32'h0000_0100);
        rd(5'h10, r);
        check(r[10:8] == 3'd0, "R8 cleared", {29'd0, r[10:8]}, 0);

        // R9 auto-run replay
        wr(5'h11, 32'h0022_1007);
        @(negedge clk);
        wr(5'h00, 32'h0000_0000);
        check(xfer_valid == 1'b0, "R9 mask off", {31'd0, xfer_valid}, 0);
        wr(5'h12, 32'h0001_0002);
        wr(5'h01, 32'h0000_1002);
        check(xfer_valid && xfer_regno == 16'h1007, "R9 data replay regno",
              {16'd0, xfer_regno}, 32'h1007);
        @(negedge clk);
        rd(5'h00, r);
        check(r == 32'hA500_1007, "R9 replay result", r, 32'hA500_1007);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = 5'h08;
        @(negedge clk);
        reg_re = 1'b0; reg_addr = 5'h1F;
        check(xfer_valid && xfer_regno == 16'h1007, "R9 progbuf replay",
              {31'd0, xfer_valid}, 1);
        @(negedge clk);
        wr(5'h12, 32'h0);

        // R10 follow captured hart
        hart_sel = 2'd2; hart_ready = 4'b0001;
        wr(5'h11, 32'h0022_100A);
        hart_sel = 2'd0;
        repeat (3) @(negedge clk);
        check(xfer_valid && xfer_hart == 2'd2, "R10 other hart ready", {31'd0, xfer_valid}, 1);
        hart_ready = 4'b0100;
        @(negedge clk);
        check(xfer_valid == 1'b0, "R10 own ready", {31'd0, xfer_valid}, 0);
        rd(5'h00, r);
        check(r == 32'hA502_100A, "R10 data0", r, 32'hA502_100A);
        hart_sel = 2'd2; hart_ready = 4'b0000;
        wr(5'h11, 32'h0022_100B);
        hart_sel = 2'd0;
        hart_halted = 4'b1011;
        @(negedge clk);
        check(xfer_valid == 1'b0, "R10 abort", {31'd0, xfer_valid}, 0);
        rd(5'h10, r);
        check(r[10:8] == 3'd4, "R10 abort code", {29'd0, r[10:8]}, 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule